// File: doc/BRIEF.md
# Gated Synchronous Frequency Meter

This block measures the frequency of a free-running, asynchronous square wave using only the fixed system clock. The raw input is brought into the clock domain through a flip-flop synchronizer. A third registered copy marks each low-to-high transition as a one-cycle event. A prescaler counts system-clock cycles and closes a gate window of fixed length. During each window a tally counts the rising-edge events. When the window closes, the tally is copied to the result register, a one-cycle valid pulse is raised, and counting starts again from zero.

With the default settings the clock is 50 MHz and the window is 5000 cycles, which is 100 µs. One count then stands for 10 kHz, the reciprocal of the window. The four-digit result therefore reads directly as MHz with two decimals: a result of 1234 means 12.34 MHz. The window length is a parameter. A simulation can use a short window, while hardware uses the full one.

The result leaves the block as a one-cycle pulse with no back-pressure. No ready input exists: `meas_valid` is high for exactly one cycle per window. The consumer must take `meas_count` and `meas_sat` on that cycle, or at any cycle before the next pulse, because both hold their value until then. The flag and the count are not reported on separate pulses.

Top module: `freq_meter`

## Requirements
- R1: While `rst_n` is low, and after its release until the first pulse, `meas_count` is 0, `meas_valid` is 0 and `meas_sat` is 0. Reset also restarts the gate window.
- R2: `meas_valid` is high for exactly one clock cycle. The first pulse appears GATE_CYCLES clock cycles after reset is released, and later pulses follow every GATE_CYCLES cycles.
- R3: Each pulse presents the number of rising edges of `sig_in` seen in the window that just closed. Each edge is counted exactly once, and a level that stays high adds nothing more.
- R4: The tally restarts from zero in every window. An edge detected in the cycle the window closes counts toward the next window. For an input whose period in clock cycles divides GATE_CYCLES, every steady-state window therefore reports exactly GATE_CYCLES/period.
- R5: If a window holds more than MAX_COUNT edges, `meas_count` reports MAX_COUNT and `meas_sat` is 1 for that result. A window holding exactly MAX_COUNT edges reports MAX_COUNT with `meas_sat` at 0.
- R6: Between pulses, `meas_count` and `meas_sat` keep the value latched at the last pulse.
- R7: A constant input, high or low, reports 0. Falling edges are never counted.
- R8: An input at half the clock rate (a period of two cycles) is counted correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of fixed frequency |
| rst_n | input | 1 | Asynchronous reset, active low |
| sig_in | input | 1 | Raw asynchronous signal to be measured |
| meas_count | output | $clog2(MAX_COUNT+1) | Rising-edge count of the last closed window |
| meas_valid | output | 1 | One-cycle pulse when a new result is latched |
| meas_sat | output | 1 | Result was clipped at MAX_COUNT |

## Verification
The assertions assume `sig_in` never toggles faster than half the clock rate. Under that assumption every transition survives the synchronizer, and the count can reach MAX_COUNT only through genuine edges. The bench drives `sig_in` on the falling clock edge with integer periods of two cycles or more, so the input stays within this limit. It also picks periods that divide the window length, which makes each steady-state window count exact whatever the phase. After each change of period, the bench lets two windows pass before it checks a result. This keeps the transient window and the pipeline delay away from the checked result.

// File: rtl/freq_meter_pkg.sv
package freq_meter_pkg;

  // 50 MHz system clock and a 100 us gate give 10 kHz per count.
  localparam int unsigned DEF_GATE_CYCLES = 5000;
  localparam int unsigned DEF_MAX_COUNT   = 9999;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  // Result of one closed window, before it is registered at the output.
  typedef struct packed {
    logic clipped;
    logic closing;
  } window_flags_t;

endpackage

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic rise_evt
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  // Synchronizer chain: stage 0 samples the raw pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= raw_in;
  end

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[k] <= 1'b0;
        else        chain[k] <= chain[k-1];
      end
    end
  endgenerate

  // Registered copy of the last stage, used only to detect a transition.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= chain[STAGES-1];
  end

  assign rise_evt = chain[STAGES-1] & ~prev_q;
endmodule

// File: rtl/fm_gate_timer.sv
module fm_gate_timer #(
  parameter int unsigned GATE_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_close
);
  localparam int unsigned TW = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
  localparam logic [TW-1:0] LAST = TW'(GATE_CYCLES - 1);

  logic [TW-1:0] tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              tick_q <= '0;
    else if (tick_q == LAST) tick_q <= '0;
    else                     tick_q <= tick_q + 1'b1;
  end

  // High during the last cycle of each window.
  assign gate_close = (tick_q == LAST);
endmodule

// File: rtl/fm_edge_tally.sv
module fm_edge_tally #(
  parameter int unsigned MAX_COUNT = 9999,
  localparam int unsigned CW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_evt,
  input  logic          gate_close,
  output logic [CW-1:0] tally,
  output logic          clipped
);
  localparam logic [CW-1:0] TOP = CW'(MAX_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tally   <= '0;
      clipped <= 1'b0;
    end else if (gate_close) begin
      // An edge in the closing cycle opens the next window's count.
      tally   <= rise_evt ? CW'(1) : '0;
      clipped <= 1'b0;
    end else if (rise_evt) begin
      if (tally == TOP) clipped <= 1'b1;
      else              tally   <= tally + 1'b1;
    end
  end
endmodule

// File: rtl/fm_result_reg.sv
module fm_result_reg #(
  parameter int unsigned CW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_close,
  input  logic [CW-1:0] tally,
  input  logic          clipped,
  output logic [CW-1:0] res_count,
  output logic          res_sat,
  output logic          res_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_count <= '0;
      res_sat   <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= gate_close;
      if (gate_close) begin
        res_count <= tally;
        res_sat   <= clipped;
      end
    end
  end
endmodule

// File: rtl/freq_meter.sv
module freq_meter
  import freq_meter_pkg::*;
#(
  parameter int unsigned GATE_CYCLES = DEF_GATE_CYCLES,
  parameter int unsigned MAX_COUNT   = DEF_MAX_COUNT,
  parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES,
  localparam int unsigned CW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sig_in,
  output logic [CW-1:0] meas_count,
  output logic          meas_valid,
  output logic          meas_sat
);
  logic          rise_evt;
  logic [CW-1:0] tally;
  window_flags_t wflags;

  fm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (sig_in),
    .rise_evt (rise_evt)
  );

  fm_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_close (wflags.closing)
  );

  fm_edge_tally #(.MAX_COUNT(MAX_COUNT)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise_evt   (rise_evt),
    .gate_close (wflags.closing),
    .tally      (tally),
    .clipped    (wflags.clipped)
  );

  fm_result_reg #(.CW(CW)) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .gate_close (wflags.closing),
    .tally      (tally),
    .clipped    (wflags.clipped),
    .res_count  (meas_count),
    .res_sat    (meas_sat),
    .res_valid  (meas_valid)
  );
endmodule

// File: rtl/freq_meter_checker.sv
module freq_meter_checker #(
  parameter int unsigned GATE_CYCLES = 5000,
  parameter int unsigned MAX_COUNT   = 9999,
  localparam int unsigned CW = $clog2(MAX_COUNT + 1),
  localparam int unsigned GW = $clog2(GATE_CYCLES + 2)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] meas_count,
  input logic          meas_valid,
  input logic          meas_sat
);
  // Cycles since reset release or since the last pulse.
  logic [GW-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_q <= '0;
    else if (meas_valid) gap_q <= GW'(1);
    else if (gap_q <= GW'(GATE_CYCLES)) gap_q <= gap_q + 1'b1;
  end

  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |=> !meas_valid);

  assert_pulse_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_valid |-> gap_q == GW'(GATE_CYCLES));

  assert_no_late_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GW'(GATE_CYCLES));

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_count <= CW'(MAX_COUNT));

  assert_sat_at_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    meas_sat |-> meas_count == CW'(MAX_COUNT));

  assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_valid |-> $stable(meas_count) && $stable(meas_sat));
endmodule

bind freq_meter freq_meter_checker #(
  .GATE_CYCLES(GATE_CYCLES),
  .MAX_COUNT  (MAX_COUNT)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .meas_count (meas_count),
  .meas_valid (meas_valid),
  .meas_sat   (meas_sat)
);

// File: tb/tb_freq_meter.sv
`timescale 1ns/1ps
module tb_freq_meter;
  localparam int unsigned G   = 120;
  localparam int unsigned MAX = 30;
  localparam int unsigned CW  = $clog2(MAX + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sig_in = 1'b0;
  logic [CW-1:0] meas_count;
  logic          meas_valid;
  logic          meas_sat;

  int checks = 0;
  int fails  = 0;
  int per    = 0;   // 0 = hold constant level
  bit lvl    = 1'b0;
  int ph     = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  freq_meter #(.GATE_CYCLES(G), .MAX_COUNT(MAX)) dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in),
    .meas_count(meas_count), .meas_valid(meas_valid), .meas_sat(meas_sat)
  );

  // Input generator, driven away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (per == 0) sig_in = lvl;
      else begin
        ph = (ph + 1 >= per) ? 0 : ph + 1;
        sig_in = (ph < per / 2);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait for the next pulse; return cycles waited.
  task automatic wait_pulse(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!meas_valid && cyc < 4 * G);
  endtask

  // Run with a given period, drop two windows, then check one result.
  task automatic measure(input int p, input int exp_cnt, input int exp_sat, input string req);
    int cyc;
    per = p; ph = 0;
    wait_pulse(cyc);
    wait_pulse(cyc);
    wait_pulse(cyc);
    check({req, " gap"}, cyc, G);
    check({req, " count"}, meas_count, exp_cnt);
    check({req, " sat"}, meas_sat, exp_sat);
    @(negedge clk);
    check("R2 pulse width", meas_valid, 0);
    check("R6 count held", meas_count, exp_cnt);
  endtask

  task automatic test_reset_state;
    check("R1 count", meas_count, 0);
    check("R1 valid", meas_valid, 0);
    check("R1 sat", meas_sat, 0);
  endtask

  task automatic test_first_pulse;
    int cyc;
    per = 6; ph = 0;
    @(negedge clk); rst_n = 1'b1;
    wait_pulse(cyc);
    check("R2 first pulse delay", cyc, G);
  endtask

  task automatic test_mid_reset;
    int cyc;
    per = 2;
    repeat (G / 2) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid count", meas_count, 0);
    check("R1 mid valid", meas_valid, 0);
    check("R1 mid sat", meas_sat, 0);
    rst_n = 1'b1;
    wait_pulse(cyc);
    check("R1 restart delay", cyc, G);
  endtask

  task automatic test_constant(input bit level);
    per = 0; lvl = level;
    measure(0, 0, 0, level ? "R7 steady high" : "R7 steady low");
  endtask

  initial begin
    #1;
    test_reset_state();
    repeat (3) @(negedge clk);
    test_reset_state();
    test_first_pulse();
    measure(12, 10, 0, "R3 period 12");
    measure(5, 24, 0, "R4 period 5");
    measure(40, 3, 0, "R4 period 40");
    measure(4, 30, 0, "R5 exactly max");
    measure(3, 30, 1, "R5 clipped period 3");
    measure(6, 20, 0, "R5 clear after clip");
    measure(2, 30, 1, "R8 half rate");
    test_constant(1'b1);
    test_constant(1'b0);
    measure(120, 1, 0, "R3 one edge per window");
    test_mid_reset();
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 150000) begin
      @(negedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", n, 0);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule